// File: doc/BRIEF.md
# Address-Mark Mute UART Receiver

This block receives asynchronous serial frames on a single line. It samples the line on a tick that runs at sixteen times the bit rate and assembles each frame into a data word. The data field can be 7, 8 or 9 bits long, and one bit of it can serve as parity. It raises a data-ready flag when a word arrives, and a parity error flag and a framing error flag travel with each delivered word.

For multi-drop buses where many receivers share one line, the block has a mute mode keyed on address frames. A frame is an address frame when the top bit of its payload is set. An address frame that carries this node's address takes the receiver out of mute. Any other address frame puts the receiver into mute, whether or not it was muted before. While muted, frames are still decoded but never raise data-ready, and the output word is left as it was. Software can also request mute. That request takes effect only once the pending data-ready flag has been cleared.

Top module: `mute_rx`

## Requirements
- R1: `wlen` sets the data field length: 00 gives 8 bits, 01 gives 9 bits, 10 gives 7 bits, and 11 is treated as 8. Bits arrive LSB first after one low start bit and are followed by one stop bit. `rx_word` bit i holds field bit i, and the bits above the field read 0.
- R2: With `par_en` high, the last field bit is the parity bit. It stays in `rx_word` at the field's top position (bit 7, 8 or 6 for `wlen` 00, 01, 10), and the payload is the bits below it.
- R3: Parity check. With `par_odd` 0, the payload plus the parity bit must hold an even number of ones. With `par_odd` 1, the count must be odd. A mismatch sets `par_err` together with the delivered word. With `par_en` low, `par_err` is 0.
- R4: Sampling is at mid-bit using `tick` at 16 per bit. A start bit is low on the tick that detects it. If the line is high again 8 ticks later, the start is dropped as a glitch: no word is delivered and the next frame is received correctly.
- R5: A stop bit sampled low sets `frm_err`, and the word is still delivered.
- R6: A frame is an address frame when the payload MSB is 1. It matches when payload bits [3:0] equal `node_addr`.
- R7: While `muted` is 1, data frames and non-matching address frames leave `rdy` low and `rx_word` unchanged.
- R8: A matching address frame clears `muted` and is delivered with `rdy`. The data frames that follow are then each delivered.
- R9: While not muted, a non-matching address frame sets `muted` and is not delivered.
- R10: A one-cycle pulse on `mute_req` sets `muted`. While `rdy` is high, entry is held off, and it happens within 3 cycles after `rdy` falls.
- R11: With `mute_en` low, `muted` reads 0 and every frame is delivered.
- R12: Reset clears `rdy`, `muted`, `rx_word` and both error flags. `rdy` stays high until a `rdy_clr` pulse, which clears it on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx | input | 1 | Serial line, idle high |
| tick | input | 1 | Sample enable at 16 times the bit rate |
| wlen | input | 2 | Data field length select |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | Parity select: 0 even, 1 odd |
| node_addr | input | 4 | This node's address |
| mute_en | input | 1 | Enables mute mode |
| mute_req | input | 1 | One-cycle request to enter mute |
| rdy_clr | input | 1 | One-cycle clear of `rdy` |
| rx_word | output | 9 | Last delivered data field |
| rdy | output | 1 | Data-ready flag |
| par_err | output | 1 | Parity error of the delivered word |
| frm_err | output | 1 | Framing error of the delivered word |
| muted | output | 1 | Current mute state |

## Verification
The stop bit is sampled 8 ticks into its bit time. `rdy`, `rx_word`, both error flags and `muted` all change one clock after that sample. The bench holds the stop bit for its full 16 ticks and then idles for 12 more ticks before it reads any of them, so every result of a frame is settled when it is read. A `rdy_clr` pulse takes effect at the next clock edge, and the bench reads `rdy` at the following falling edge. A mute request waiting on `rdy` completes within two clocks of the clear, and the bench reads `muted` three falling edges later.

// File: rtl/mute_rx.sv
module mute_rx #(
  parameter int OSR = 16,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx,
  input  logic          tick,
  input  logic [1:0]    wlen,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic [AW-1:0] node_addr,
  input  logic          mute_en,
  input  logic          mute_req,
  input  logic          rdy_clr,
  output logic [8:0]    rx_word,
  output logic          rdy,
  output logic          par_err,
  output logic          frm_err,
  output logic          muted
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] sc;
  logic [3:0]    bi;
  logic [8:0]    sh;
  logic          pend;
  logic [3:0]    nbits, pmsb;
  logic          fin, is_addr, hit, perr, deliver;

  assign nbits   = (wlen == 2'b01) ? 4'd9 : (wlen == 2'b10) ? 4'd7 : 4'd8;
  assign pmsb    = nbits - 4'd1 - {3'd0, par_en};
  assign fin     = tick && (st == S_STOP) && (sc == LAST);
  assign is_addr = sh[pmsb];
  assign hit     = (sh[AW-1:0] == node_addr);
  assign perr    = par_en && ((^sh) != par_odd);
  assign deliver = !mute_en || (is_addr ? hit : !muted);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      sc <= '0;
      bi <= '0;
      sh <= '0;
    end else if (tick) begin
      sc <= sc + 1'b1;
      case (st)
        S_IDLE: begin
          sc <= '0;
          if (!rx) st <= S_START;
        end
        S_START:
          if (sc == MID) begin
            sc <= '0;
            if (rx) st <= S_IDLE;
            else begin
              st <= S_DATA;
              bi <= '0;
              sh <= '0;
            end
          end
        S_DATA:
          if (sc == LAST) begin
            sh[bi] <= rx;
            if (bi == nbits - 4'd1) st <= S_STOP;
            else bi <= bi + 4'd1;
          end
        S_STOP:
          if (sc == LAST) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_word <= '0;
      rdy     <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
      muted   <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (rdy_clr) rdy <= 1'b0;
      if (mute_req) pend <= 1'b1;
      if (fin) begin
        if (deliver) begin
          rdy     <= 1'b1;
          rx_word <= sh;
          par_err <= perr;
          frm_err <= !rx;
        end
        if (mute_en && is_addr) muted <= !hit;
      end else if (pend && !rdy && mute_en) begin
        muted <= 1'b1;
        pend  <= 1'b0;
      end
      if (!mute_en) begin
        muted <= 1'b0;
        pend  <= 1'b0;
      end
    end
endmodule

// File: rtl/mute_rx_chk.sv
module mute_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rdy_clr,
  input logic       mute_en,
  input logic [1:0] wlen,
  input logic       fin,
  input logic       rdy,
  input logic       muted,
  input logic [8:0] rx_word
);
  a_r12_rdy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rdy && !rdy_clr |=> rdy);
  a_r12_rdy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_clr && !fin |=> !rdy);
  a_r7_rise_unmuted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> !muted);
  a_r10_entry_waits: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(muted) |-> $past(fin) || !$past(rdy));
  a_r11_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_en |=> !muted);
  a_r7_word_on_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word) |-> rdy && $past(fin));
  a_r1_short_field: assert property (@(posedge clk) disable iff (!rst_n)
    rdy && $past(fin) && $past(wlen) == 2'b10 |-> rx_word[8:7] == 2'b00);
endmodule

bind mute_rx mute_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_clr(rdy_clr), .mute_en(mute_en), .wlen(wlen),
  .fin(fin), .rdy(rdy), .muted(muted), .rx_word(rx_word)
);

// File: tb/sim_mute_rx.sv
module sim_mute_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic tick = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic [1:0] wlen = 2'b00;
  logic par_en = 1'b0, par_odd = 1'b0, men = 1'b0, mute_req = 1'b0, rdy_clr = 1'b0;
  logic [3:0] node = 4'h5;
  logic [8:0] rx_word;
  logic rdy, par_err, frm_err, muted;

  int nchk = 0, nerr = 0;
  bit m_muted = 1'b0;
  logic [8:0] last = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  mute_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx(rx), .tick(tick), .wlen(wlen), .par_en(par_en),
    .par_odd(par_odd), .node_addr(node), .mute_en(men), .mute_req(mute_req),
    .rdy_clr(rdy_clr), .rx_word(rx_word), .rdy(rdy), .par_err(par_err),
    .frm_err(frm_err), .muted(muted)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      do @(posedge clk); while (!tick);
    end
  endtask

  task automatic send(input logic [8:0] field, input int nb, input bit stop_ok);
    wait_ticks(1);
    #1 rx = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < nb; i++) begin
      #1 rx = field[i];
      wait_ticks(16);
    end
    #1 rx = stop_ok;
    wait_ticks(16);
    #1 rx = 1'b1;
    wait_ticks(12);
    @(negedge clk);
  endtask

  task automatic clear_rdy();
    @(negedge clk) rdy_clr = 1'b1;
    @(negedge clk) rdy_clr = 1'b0;
    check(rdy == 1'b0, "R12 clear", rdy, 0);
  endtask

  task automatic run_frame(input logic [1:0] wl, input bit pe, input bit po, input logic [8:0] raw,
                           input bit corrupt, input bit stop_ok, input bit keep, input string tag);
    int nb, pb;
    logic [8:0] pay, field;
    bit par, is_a, hit, dlv;
    nb = (wl == 2'b01) ? 9 : (wl == 2'b10) ? 7 : 8;
    pb = nb - (pe ? 1 : 0);
    pay = raw & ((9'd1 << pb) - 9'd1);
    par = (^pay) ^ po ^ corrupt;
    field = pe ? (pay | (9'(par) << pb)) : pay;
    is_a = pay[pb-1];
    hit = (pay[3:0] == node);
    if (!men) dlv = 1'b1;
    else if (is_a) begin
      dlv = hit;
      m_muted = !hit;
    end else dlv = !m_muted;
    wlen = wl;
    par_en = pe;
    par_odd = po;
    send(field, nb, stop_ok);
    check(rdy == dlv, {tag, " rdy"}, rdy, dlv);
    if (dlv) begin
      check(rx_word == field, {tag, " R1 R2 word"}, rx_word, field);
      check(par_err == (pe && corrupt), {tag, " R3 par_err"}, par_err, pe && corrupt);
      check(frm_err == !stop_ok, {tag, " R5 frm_err"}, frm_err, !stop_ok);
      last = field;
    end else
      check(rx_word == last, {tag, " R7 word held"}, rx_word, last);
    check(muted == m_muted, {tag, " muted"}, muted, m_muted);
    if (!keep && rdy) clear_rdy();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    check(rdy == 0 && muted == 0 && rx_word == 0 && par_err == 0 && frm_err == 0,
          "R12 reset", {rdy, muted, par_err, frm_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_frame(2'b00, 0, 0, 9'h0A5, 0, 1, 0, "R1 R11 len8");
    run_frame(2'b01, 0, 0, 9'h1C3, 0, 1, 0, "R1 R11 len9 addr-like");
    run_frame(2'b10, 0, 0, 9'h1FF, 0, 1, 0, "R1 len7");
    run_frame(2'b11, 0, 0, 9'h15A, 0, 1, 0, "R1 len code 11");
    run_frame(2'b00, 1, 0, 9'h035, 0, 1, 0, "R2 R3 even ok");
    run_frame(2'b00, 1, 1, 9'h035, 0, 1, 0, "R2 R3 odd ok");
    run_frame(2'b01, 1, 0, 9'h0F1, 1, 1, 0, "R3 even bad");
    run_frame(2'b10, 1, 1, 9'h02C, 1, 1, 0, "R3 odd bad");
    run_frame(2'b00, 0, 0, 9'h066, 0, 0, 0, "R5 bad stop");

    wait_ticks(1);
    #1 rx = 1'b0;
    wait_ticks(3);
    #1 rx = 1'b1;
    wait_ticks(12);
    @(negedge clk);
    check(rdy == 1'b0, "R4 glitch no word", rdy, 0);
    check(rx_word == last, "R4 glitch word held", rx_word, last);
    run_frame(2'b00, 0, 0, 9'h0B4, 0, 1, 0, "R4 after glitch");

    men = 1'b1;
    run_frame(2'b00, 0, 0, 9'h083, 0, 1, 0, "R6 R9 nonmatch addr");
    run_frame(2'b00, 0, 0, 9'h012, 0, 1, 0, "R7 muted data");
    run_frame(2'b00, 0, 0, 9'h087, 0, 1, 0, "R7 muted nonmatch");
    run_frame(2'b00, 0, 0, 9'h095, 0, 1, 0, "R6 R8 match addr");
    run_frame(2'b00, 0, 0, 9'h021, 0, 1, 0, "R8 data after match");
    run_frame(2'b00, 1, 0, 9'h045, 0, 1, 1, "R8 data parity");

    @(negedge clk) mute_req = 1'b1;
    @(negedge clk) mute_req = 1'b0;
    repeat (3) @(negedge clk);
    check(muted == 1'b0, "R10 held while rdy", muted, 0);
    clear_rdy();
    repeat (3) @(negedge clk);
    check(muted == 1'b1, "R10 entered after clear", muted, 1);
    m_muted = 1'b1;
    run_frame(2'b00, 0, 0, 9'h033, 0, 1, 0, "R10 R7 muted after req");

    for (int k = 0; k < 60; k++) begin
      logic [8:0] raw;
      men = ($urandom % 8) != 0;
      if (!men) m_muted = 1'b0;
      raw = 9'($urandom);
      if ($urandom % 3 == 0) raw[3:0] = node;
      run_frame(2'($urandom % 3), 1'($urandom), 1'($urandom), raw,
                ($urandom % 5) == 0, ($urandom % 7) != 0, 0, "R1 R3 R7 R8 R9 R11 random");
      if (men && ($urandom % 8) == 0) begin
        @(negedge clk) mute_req = 1'b1;
        @(negedge clk) mute_req = 1'b0;
        repeat (3) @(negedge clk);
        m_muted = 1'b1;
        check(muted == 1'b1, "R10 random req", muted, 1);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule